// File: doc/BRIEF.md
# Frequency-Change Recovery Watchdog

This block guards a programmable clock generator against a system that hangs after software selects a new output frequency. Software writes a small set of byte-wide registers through a simple write port. One register sets a timeout and the recovery options. Two other paths request a new frequency code: a direct write, or a staged code followed by a commit. If a nonzero timeout is already in place when a new code is applied, a watchdog timer starts at once. Software is expected to prove that the system survived by writing a zero timeout before the timer runs out.

A central state machine has four states: `ST_IDLE`, `ST_ARMED`, `ST_WARNED` and `ST_FALLBACK`.

- `ST_IDLE` moves to `ST_ARMED` when a frequency change arrives while the timeout field is nonzero.
- `ST_ARMED` moves to `ST_WARNED` on the first expiry. That expiry gives a reset pulse and raises the alarm. The frequency stays as it is.
- `ST_WARNED` moves to `ST_FALLBACK` on the second expiry. That expiry gives a pulse, raises the alarm and loads a fallback code.
- `ST_FALLBACK` loops on itself on every later expiry and repeats the same action each time.
- Any state returns to `ST_IDLE` on a write of a zero timeout.
- A frequency change in any armed state returns to `ST_ARMED` with a fresh count.

The fallback code is either the strap code latched just after reset or the software code that was in effect before the most recent change.

Top module: `freq_recovery_wdt`

## Requirements
- R1: Two cycles after reset is released, `freq_code` equals `strap_code`, `sys_rst_n` is 1 and `wdt_alarm` is 0. `sys_rst_n` stays 1 while `rst_n` is low.
- R2: A write to address 4 places `wr_data[FREQ_W-1:0]` on `freq_code` one cycle later. Upper data bits are dropped.
- R3: A write to address 13 stages a code without changing `freq_code`. A write to address 14 with data bit 0 set applies the staged code. A write to address 14 with bit 0 clear has no effect.
- R4: Address 12 is the control register: bits 3:0 are the timeout field, bit 6 is the fallback select and bit 7 is the pulse enable. If the field is nonzero when a change is applied, the first low cycle of `sys_rst_n` comes exactly field × `STEP_CYCLES` clock edges after the applying edge.
- R5: A frequency change made while the timeout field is 0 starts no timer and gives no reset pulse.
- R6: On the first expiry, `sys_rst_n` goes low for exactly `PULSE_LEN` cycles, `wdt_alarm` becomes 1 and `freq_code` does not change.
- R7: On the second expiry a further pulse is driven. `freq_code` then takes the previous software code when control bit 6 is 0, or the latched strap code when bit 6 is 1.
- R8: After each expiry the timer restarts with the same period. Every later expiry repeats the pulse and the fallback load.
- R9: Writing address 12 with bits 3:0 equal to 0 stops the timer, clears `wdt_alarm` and keeps the current `freq_code`.
- R10: With control bit 7 at 0, expiries drive no pulse, but the alarm and the fallback load still take place.
- R11: Bit 4 of a write to address 12 is ignored. It cannot set `wdt_alarm`.
- R12: A frequency change while the timer is armed restarts the full period and returns the sequence to its first-expiry stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| strap_code | input | FREQ_W | Hardware strap frequency code, latched after reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| freq_code | output | FREQ_W | Frequency code in effect |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wdt_alarm | output | 1 | Watchdog alarm status |

## Verification
A table of direct writes with different values, including one with stray upper bits, shows whether the code path truncates the data correctly. The staged-then-commit sequence, with and without the commit bit, separates staging from applying.

The timed runs use both fallback selections, with the pulse enabled and with it disabled. They show apart the first-expiry behaviour from the second, the strap source from the previous-software source, and the pulse from the alarm. They also measure the exact period and pulse width.

A change made while the timer is armed, a write to the alarm bit and a zero timeout written between runs cover the restart, ignore and disarm paths.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_WARNED   = 2'd2,
        ST_FALLBACK = 2'd3
    } wdt_state_t;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int TMO_W  = 4;

    localparam logic [ADDR_W-1:0] ADDR_FREQ   = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_CTL    = 4'd12;
    localparam logic [ADDR_W-1:0] ADDR_STAGE  = 4'd13;
    localparam logic [ADDR_W-1:0] ADDR_COMMIT = 4'd14;

    localparam int CTL_FB_BIT  = 6;
    localparam int CTL_RST_BIT = 7;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int FREQ_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FREQ_W-1:0]   strap_code,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                fb_load,
    output logic [FREQ_W-1:0]   freq_code,
    output logic [TMO_W-1:0]    tmo_field,
    output logic                rst_en,
    output logic                sw_chg,
    output logic                disarm
);

    logic              taken_q;
    logic [FREQ_W-1:0] freq_q;
    logic [FREQ_W-1:0] prev_q;
    logic [FREQ_W-1:0] strap_q;
    logic [FREQ_W-1:0] stage_q;
    logic              fb_sel_q;
    logic [FREQ_W-1:0] new_code;
    logic              wr_ctl;

    assign wr_ctl    = wr_en && (wr_addr == ADDR_CTL);
    assign disarm    = wr_ctl && (wr_data[TMO_W-1:0] == '0);
    assign sw_chg    = taken_q && wr_en &&
                       ((wr_addr == ADDR_FREQ) || ((wr_addr == ADDR_COMMIT) && wr_data[0]));
    assign new_code  = (wr_addr == ADDR_FREQ) ? wr_data[FREQ_W-1:0] : stage_q;
    assign freq_code = taken_q ? freq_q : strap_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q   <= 1'b0;
            freq_q    <= '0;
            prev_q    <= '0;
            strap_q   <= '0;
            stage_q   <= '0;
            tmo_field <= '0;
            fb_sel_q  <= 1'b0;
            rst_en    <= 1'b0;
        end else begin
            if (!taken_q) begin
                taken_q <= 1'b1;
                strap_q <= strap_code;
                freq_q  <= strap_code;
                prev_q  <= strap_code;
            end else if (sw_chg) begin
                prev_q <= freq_q;
                freq_q <= new_code;
            end else if (fb_load) begin
                freq_q <= fb_sel_q ? strap_q : prev_q;
            end
            if (wr_ctl) begin
                tmo_field <= wr_data[TMO_W-1:0];
                fb_sel_q  <= wr_data[CTL_FB_BIT];
                rst_en    <= wr_data[CTL_RST_BIT];
            end
            if (wr_en && (wr_addr == ADDR_STAGE)) begin
                stage_q <= wr_data[FREQ_W-1:0];
            end
        end
    end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int STEP_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             stop,
    input  logic [TMO_W-1:0] tmo_field,
    output logic             fire
);

    localparam int CW = TMO_W + $clog2(STEP_CYCLES + 1) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_val;

    assign load_val = CW'(tmo_field) * CW'(STEP_CYCLES);
    assign fire     = (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (stop) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic pulse_n
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_q;

    assign pulse_n = (left_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (go) begin
            left_q <= PW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - PW'(1);
        end
    end

endmodule

// File: rtl/freq_recovery_wdt.sv
module freq_recovery_wdt
    import wdt_pkg::*;
#(
    parameter int FREQ_W      = 5,
    parameter int STEP_CYCLES = 1024,
    parameter int PULSE_LEN   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] strap_code,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [FREQ_W-1:0] freq_code,
    output logic              sys_rst_n,
    output logic              wdt_alarm
);

    wdt_state_t       state_q;
    wdt_state_t       state_d;
    logic [TMO_W-1:0] tmo_field;
    logic             rst_en;
    logic             sw_chg;
    logic             disarm;
    logic             tmo_fire;
    logic             fb_load;
    logic             tmr_load;
    logic             tmr_stop;
    logic             pulse_go;
    logic             alarm_q;

    wdt_regs #(.FREQ_W(FREQ_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_code (strap_code),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fb_load    (fb_load),
        .freq_code  (freq_code),
        .tmo_field  (tmo_field),
        .rst_en     (rst_en),
        .sw_chg     (sw_chg),
        .disarm     (disarm)
    );

    wdt_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tmr_load),
        .stop      (tmr_stop),
        .tmo_field (tmo_field),
        .fire      (tmo_fire)
    );

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (pulse_go),
        .pulse_n (sys_rst_n)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (disarm) begin
            state_d = ST_IDLE;
        end else if (sw_chg && (tmo_field != '0)) begin
            state_d = ST_ARMED;
        end else if (tmo_fire) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ARMED:    state_d = ST_WARNED;
                ST_WARNED:   state_d = ST_FALLBACK;
                ST_FALLBACK: state_d = ST_FALLBACK;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs of the machine
    always_comb begin
        tmr_stop = (state_d == ST_IDLE);
        tmr_load = (state_d != ST_IDLE) && (sw_chg || tmo_fire);
        pulse_go = 1'b0;
        fb_load  = 1'b0;
        if (tmo_fire && !disarm) begin
            unique case (state_q)
                ST_IDLE:     pulse_go = 1'b0;
                ST_ARMED:    pulse_go = rst_en;
                ST_WARNED,
                ST_FALLBACK: begin
                    pulse_go = rst_en;
                    fb_load  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if (disarm) begin
            alarm_q <= 1'b0;
        end else if (tmo_fire && (state_q != ST_IDLE)) begin
            alarm_q <= 1'b1;
        end
    end

    assign wdt_alarm = alarm_q;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
    import wdt_pkg::*;
#(
    parameter int FREQ_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic [FREQ_W-1:0] freq_code,
    input logic              sys_rst_n,
    input logic              wdt_alarm,
    input wdt_state_t        state,
    input logic              tmo_fire,
    input logic              chg
);

    // R2
    freq_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_FREQ && chg) |=> freq_code == $past(wr_data[FREQ_W-1:0]));

    // R6
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> $past(tmo_fire));

    // R9
    disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTL && wr_data[3:0] == 4'd0) |=> !wdt_alarm);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !tmo_fire);

    // R6
    first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && tmo_fire && !chg) |=> $stable(freq_code));

    // R11
    alarm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_alarm) |-> $past(tmo_fire));

endmodule

bind freq_recovery_wdt wdt_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .freq_code (freq_code),
    .sys_rst_n (sys_rst_n),
    .wdt_alarm (wdt_alarm),
    .state     (state_q),
    .tmo_fire  (tmo_fire),
    .chg       (sw_chg)
);

// File: tb/sim_freq_recovery_wdt.sv
module sim_freq_recovery_wdt;

    localparam int FW    = 5;
    localparam int STEP  = 8;
    localparam int PLEN  = 16;
    localparam logic [FW-1:0] STRAP = 5'h0B;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] strap_code = STRAP;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [FW-1:0] freq_code;
    logic          sys_rst_n;
    logic          wdt_alarm;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nfall  = 0;
    int tfall  = 0;
    int lowcnt = 0;
    int t_wr   = 0;
    logic prev_rst = 1'b1;

    localparam int NV = 4;
    localparam logic [7:0]    VEC_IN  [NV] = '{8'h03, 8'h1F, 8'hE4, 8'h10};
    localparam logic [FW-1:0] VEC_EXP [NV] = '{5'h03, 5'h1F, 5'h04, 5'h10};

    freq_recovery_wdt #(.FREQ_W(FW), .STEP_CYCLES(STEP), .PULSE_LEN(PLEN)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_code (strap_code),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .freq_code  (freq_code),
        .sys_rst_n  (sys_rst_n),
        .wdt_alarm  (wdt_alarm)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_rst && !sys_rst_n) begin
                nfall = nfall + 1;
                tfall = cyc;
            end
            if (!sys_rst_n) lowcnt = lowcnt + 1;
            prev_rst = sys_rst_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        t_wr = cyc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_fall(input int target);
        for (int i = 0; i < 400 && nfall < target; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t_prev;
        int base;
        idle(3);
        check(sys_rst_n === 1'b1, "R1 reset output high in reset", sys_rst_n, 1);
        rst_n = 1'b1;
        idle(2);
        check(freq_code === STRAP, "R1 strap code", freq_code, STRAP);
        check(wdt_alarm === 1'b0, "R1 alarm clear", wdt_alarm, 0);
        check(sys_rst_n === 1'b1, "R1 reset output high", sys_rst_n, 1);

        // R2 table walk
        for (int i = 0; i < NV; i++) begin
            wr(4'd4, VEC_IN[i]);
            check(freq_code === VEC_EXP[i], "R2 direct write", freq_code, VEC_EXP[i]);
        end

        // R3 staging and commit
        wr(4'd13, 8'h07);
        check(freq_code === 5'h10, "R3 stage only", freq_code, 5'h10);
        wr(4'd14, 8'h00);
        check(freq_code === 5'h10, "R3 commit bit clear", freq_code, 5'h10);
        wr(4'd14, 8'h01);
        check(freq_code === 5'h07, "R3 commit", freq_code, 5'h07);

        // R5 no arming with a zero field
        idle(100);
        check(nfall == 0, "R5 no pulse when field zero", nfall, 0);

        // R11 alarm bit not writable
        wr(4'd12, 8'h10);
        idle(1);
        check(wdt_alarm === 1'b0, "R11 alarm write ignored", wdt_alarm, 0);

        // R4 R6 R7 R8 with previous-software fallback
        wr(4'd12, 8'h83);
        lowcnt = 0;
        wr(4'd4, 8'h12);
        base = t_wr;
        wait_fall(1);
        check(tfall - base == 3 * STEP, "R4 timeout period", tfall - base, 3 * STEP);
        check(wdt_alarm === 1'b1, "R6 alarm set", wdt_alarm, 1);
        check(freq_code === 5'h12, "R6 freq kept", freq_code, 5'h12);
        idle(PLEN + 2);
        check(lowcnt == PLEN, "R6 pulse width", lowcnt, PLEN);
        t_prev = tfall;
        wait_fall(2);
        check(tfall - t_prev == 3 * STEP, "R8 restart period", tfall - t_prev, 3 * STEP);
        idle(2);
        check(freq_code === 5'h07, "R7 previous software fallback", freq_code, 5'h07);
        t_prev = tfall;
        wait_fall(3);
        check(tfall - t_prev == 3 * STEP, "R8 repeat period", tfall - t_prev, 3 * STEP);
        check(freq_code === 5'h07, "R8 repeat fallback", freq_code, 5'h07);

        // R9 disarm
        wr(4'd12, 8'h80);
        check(wdt_alarm === 1'b0, "R9 alarm cleared", wdt_alarm, 0);
        check(freq_code === 5'h07, "R9 freq kept", freq_code, 5'h07);
        idle(100);
        check(nfall == 3, "R9 timer stopped", nfall, 3);

        // R7 strap fallback
        wr(4'd12, 8'hC3);
        wr(4'd4, 8'h15);
        wait_fall(4);
        idle(2);
        check(freq_code === 5'h15, "R6 freq kept before second expiry", freq_code, 5'h15);
        wait_fall(5);
        idle(2);
        check(freq_code === STRAP, "R7 strap fallback", freq_code, STRAP);
        wr(4'd12, 8'h00);

        // R10 pulse disabled
        wr(4'd12, 8'h03);
        wr(4'd4, 8'h09);
        base = t_wr;
        idle(3 * STEP + 2);
        check(wdt_alarm === 1'b1, "R10 alarm without pulse", wdt_alarm, 1);
        check(nfall == 5, "R10 no pulse", nfall, 5);
        check(freq_code === 5'h09, "R10 freq kept first", freq_code, 5'h09);
        idle(3 * STEP);
        check(freq_code === STRAP, "R10 fallback without pulse", freq_code, STRAP);

        // R12 change while armed restarts
        wr(4'd12, 8'h83);
        wr(4'd4, 8'h1A);
        idle(20);
        wr(4'd4, 8'h1C);
        base = t_wr;
        wait_fall(6);
        check(tfall - base == 3 * STEP, "R12 restart on change", tfall - base, 3 * STEP);
        check(freq_code === 5'h1C, "R12 first stage again", freq_code, 5'h1C);
        wr(4'd12, 8'h00);
        check(wdt_alarm === 1'b0, "R9 final disarm", wdt_alarm, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule